// File: doc/BRIEF.md
# Pulse-Length Reader Bit Encoder

This block sends one reader command frame by switching the carrier field on and off with binary pulse-length modulation. Every bit opens with a short field-off gap. The bit value is carried by how long the bit lasts in total, not by a level or a phase. All timing is counted in carrier units, and an external unit tick marks each unit. One unit is 8 µs at a 125 kHz carrier.

A frame is loaded through a start/ready handshake. The load carries up to 160 bits of data as a flat byte buffer, a bit count, a turnaround time and the value of the last tag bit that was received. A free-running counter measures the units since the last tag edge. Before the first gap, the encoder waits until that count reaches the turnaround time. The wait is 16 units longer when the last tag bit was a one. The encoder then sends the bits, closes the frame with one more gap, leaves the field on and pulses a done flag.

Top module: `plm_reader_tx`

## Requirements
- R1: After reset and whenever it is idle, the block drives `field_on` high and `ready` high, and `done` stays low.
- R2: Every data bit starts with exactly 6 unit ticks of `field_on` low.
- R3: A zero bit lasts 22 units and a one bit lasts 28 units, counted from the start of its gap. After the gap, `field_on` is therefore high for 16 or 22 units.
- R4: Exactly `frame_len` bits are sent. Byte k is held in `frame_data[8k+7:8k]`, bytes go out in order k = 0, 1, 2 and so on, and each byte goes out from bit 7 down to bit 0. A frame may end part-way through a byte.
- R5: After the last bit, one closing gap of 6 units is sent. The field then returns high, `done` is high for exactly one clock cycle, and `ready` is high again.
- R6: Counting from the most recent `tag_edge`, the first gap starts after `turn_units` unit ticks, plus 16 more when `tag_bit_one` was high at start.
- R7: While a frame is in progress `ready` is low, and a `start` pulse has no effect: the frame on the field is unchanged and only one `done` pulse appears.
- R8: A frame with `frame_len` = 0 sends only the closing 6-unit gap.
- R9: If the turnaround time has already passed when start is accepted, the first gap begins within one unit tick.
- R10: A `frame_len` above 160 is treated as 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| unit_tick | input | 1 | One-cycle pulse per carrier unit |
| tag_edge | input | 1 | Pulse on each received tag edge; restarts the turnaround count |
| tag_bit_one | input | 1 | Last received tag bit was a one (sampled at start) |
| turn_units | input | 9 | Turnaround time in units (sampled at start) |
| start | input | 1 | Frame request, accepted when ready is high |
| frame_data | input | 160 | Frame bytes; byte k in bits [8k+7:8k] |
| frame_len | input | 8 | Number of bits to send |
| ready | output | 1 | Idle and able to accept a frame |
| field_on | output | 1 | Field control, high = carrier on |
| done | output | 1 | One-cycle pulse after the closing gap |

## Verification
Almost every internal fault shows up as a change in the length of a field segment. A unit counter that is off by one lengthens or shortens a gap or a bit body within that same bit. A wrong bit index reorders the pulse pattern or changes the number of pulses. A wrong turnaround count moves the first falling edge before the first bit starts. The bench records the field level on every unit tick and splits the record into gap and body lengths. A fault is therefore found in the first frame that uses the broken path, and the check names the segment involved.

// File: rtl/plm_tx_pkg.sv
package plm_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_GAP,
      ST_HOLD,
      ST_STOP
   } tx_state_e;

endpackage

// File: rtl/plm_turn_timer.sv
// Saturating count of unit ticks since the last tag edge.
module plm_turn_timer #(
   parameter int SINCE_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unit_tick,
   input  logic               tag_edge,
   output logic [SINCE_W-1:0] since
);
   localparam logic [SINCE_W-1:0] SAT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since <= SAT;
      else if (tag_edge)
         since <= '0;
      else if (unit_tick && since != SAT)
         since <= since + SINCE_W'(1);
   end

   AST_SINCE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_edge |=> since >= $past(since)); // R6

endmodule

// File: rtl/plm_bit_order.sv
// Maps the serial bit index onto the byte buffer, MSB of each byte first.
module plm_bit_order #(
   parameter int MAX_BITS = 160,
   parameter int CNT_W    = 8
) (
   input  logic [MAX_BITS-1:0] frame,
   input  logic [CNT_W-1:0]    idx,
   output logic                bit_val
);
   logic [MAX_BITS-1:0] ser;

   for (genvar n = 0; n < MAX_BITS; n++) begin : g_ord
      assign ser[n] = frame[8*(n/8) + 7 - (n%8)];
   end

   assign bit_val = (idx < CNT_W'(MAX_BITS)) ? ser[idx] : 1'b0;

endmodule

// File: rtl/plm_tx_seq.sv
// Frame sequencer: wait, gap/body per bit, closing gap.
module plm_tx_seq
   import plm_tx_pkg::*;
#(
   parameter int GAP_UNITS  = 6,
   parameter int ZERO_UNITS = 22,
   parameter int ONE_UNITS  = 28,
   parameter int CNT_W      = 8,
   parameter int UNIT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unit_tick,
   input  logic             go,
   input  logic [CNT_W-1:0] len_i,
   input  logic             wait_ok,
   input  logic             bit_val,
   output logic [CNT_W-1:0] idx,
   output logic             field_on,
   output logic             ready,
   output logic             done
);
   localparam logic [UNIT_W-1:0] GAP_LAST  = UNIT_W'(GAP_UNITS - 1);
   localparam logic [UNIT_W-1:0] ZERO_LAST = UNIT_W'(ZERO_UNITS - 1);
   localparam logic [UNIT_W-1:0] ONE_LAST  = UNIT_W'(ONE_UNITS - 1);

   tx_state_e         st, nx;
   logic [UNIT_W-1:0] unit, unit_nx, last_unit;
   logic [CNT_W-1:0]  idx_nx;
   logic              done_nx;

   always_comb begin
      nx        = st;
      unit_nx   = unit;
      idx_nx    = idx;
      done_nx   = 1'b0;
      last_unit = bit_val ? ONE_LAST : ZERO_LAST;
      case (st)
         ST_IDLE: if (go) begin
            nx      = ST_WAIT;
            unit_nx = '0;
            idx_nx  = '0;
         end
         ST_WAIT: if (wait_ok) begin
            nx = (len_i == '0) ? ST_STOP : ST_GAP;
         end
         ST_GAP: if (unit_tick) begin
            unit_nx = unit + UNIT_W'(1);
            if (unit == GAP_LAST) nx = ST_HOLD;
         end
         ST_HOLD: if (unit_tick) begin
            if (unit == last_unit) begin
               unit_nx = '0;
               if (idx == len_i - CNT_W'(1)) begin
                  nx = ST_STOP;
               end else begin
                  idx_nx = idx + CNT_W'(1);
                  nx     = ST_GAP;
               end
            end else begin
               unit_nx = unit + UNIT_W'(1);
            end
         end
         ST_STOP: if (unit_tick) begin
            if (unit == GAP_LAST) begin
               unit_nx = '0;
               nx      = ST_IDLE;
               done_nx = 1'b1;
            end else begin
               unit_nx = unit + UNIT_W'(1);
            end
         end
         default: nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         unit     <= '0;
         idx      <= '0;
         done     <= 1'b0;
         field_on <= 1'b1;
      end else begin
         st       <= nx;
         unit     <= unit_nx;
         idx      <= idx_nx;
         done     <= done_nx;
         field_on <= !(nx == ST_GAP || nx == ST_STOP);
      end
   end

   assign ready = (st == ST_IDLE);

   AST_IDLE_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> field_on); // R1
   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(field_on) |-> $past(unit_tick)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready && field_on); // R5
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> idx < len_i); // R4

endmodule

// File: rtl/plm_reader_tx.sv
module plm_reader_tx #(
   parameter int MAX_BITS   = 160,
   parameter int GAP_UNITS  = 6,
   parameter int ZERO_UNITS = 22,
   parameter int ONE_UNITS  = 28,
   parameter int ONE_EXTRA  = 16,
   parameter int TURN_W     = 9,
   localparam int CNT_W     = $clog2(MAX_BITS + 1),
   localparam int SINCE_W   = TURN_W + 1,
   localparam int UNIT_W    = $clog2(ONE_UNITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                unit_tick,
   input  logic                tag_edge,
   input  logic                tag_bit_one,
   input  logic [TURN_W-1:0]   turn_units,
   input  logic                start,
   input  logic [MAX_BITS-1:0] frame_data,
   input  logic [CNT_W-1:0]    frame_len,
   output logic                ready,
   output logic                field_on,
   output logic                done
);
   if (MAX_BITS % 8 != 0) begin : g_bad_bytes
      $error("MAX_BITS must be a whole number of bytes");
   end
   if (!(GAP_UNITS >= 1 && GAP_UNITS < ZERO_UNITS && ZERO_UNITS < ONE_UNITS)) begin : g_bad_units
      $error("unit lengths must satisfy 1 <= GAP < ZERO < ONE");
   end
   if (ONE_EXTRA >= (1 << TURN_W)) begin : g_bad_extra
      $error("ONE_EXTRA must fit the turnaround width");
   end

   logic [MAX_BITS-1:0] frame_q;
   logic [CNT_W-1:0]    len_q, len_clamped, idx;
   logic [SINCE_W-1:0]  target_q, target_nx, since;
   logic                accept, bit_val, wait_ok;

   assign accept      = start && ready;
   assign len_clamped = (frame_len > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : frame_len;
   assign target_nx   = {1'b0, turn_units} + (tag_bit_one ? SINCE_W'(ONE_EXTRA) : '0);
   assign wait_ok     = since >= target_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q  <= '0;
         len_q    <= '0;
         target_q <= '0;
      end else if (accept) begin
         frame_q  <= frame_data;
         len_q    <= len_clamped;
         target_q <= target_nx;
      end
   end

   plm_turn_timer #(.SINCE_W(SINCE_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_tick (unit_tick),
      .tag_edge  (tag_edge),
      .since     (since)
   );

   plm_bit_order #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_order (
      .frame   (frame_q),
      .idx     (idx),
      .bit_val (bit_val)
   );

   plm_tx_seq #(
      .GAP_UNITS  (GAP_UNITS),
      .ZERO_UNITS (ZERO_UNITS),
      .ONE_UNITS  (ONE_UNITS),
      .CNT_W      (CNT_W),
      .UNIT_W     (UNIT_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_tick (unit_tick),
      .go        (accept),
      .len_i     (len_q),
      .wait_ok   (wait_ok),
      .bit_val   (bit_val),
      .idx       (idx),
      .field_on  (field_on),
      .ready     (ready),
      .done      (done)
   );

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(len_q) && $stable(frame_q)); // R7
   AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= CNT_W'(MAX_BITS)); // R10

endmodule

// File: tb/test_plm_reader_tx.sv
module test_plm_reader_tx;
   logic         clk = 1'b0, rst_n = 1'b0;
   logic         unit_tick = 1'b0, tag_edge = 1'b0, tag_bit_one = 1'b0, start = 1'b0;
   logic [8:0]   turn_units = '0;
   logic [159:0] frame_data = '0;
   logic [7:0]   frame_len = '0;
   logic         ready, field_on, done;

   plm_reader_tx i_plm_reader_tx (
      .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .tag_edge(tag_edge),
      .tag_bit_one(tag_bit_one), .turn_units(turn_units), .start(start),
      .frame_data(frame_data), .frame_len(frame_len),
      .ready(ready), .field_on(field_on), .done(done)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0, tlen = 0, done_cnt = 0;
   bit rec = 0, fin = 0;
   bit trc [0:8191];

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Tick generation and per-tick recording of the field level.
   always @(negedge clk) begin
      bit t;
      cyc++;
      tdiv = (tdiv + 1) % 4;
      t = (tdiv == 0);
      unit_tick <= t;
      if (rec && t && tlen < 8192) begin
         trc[tlen] = field_on;
         tlen++;
      end
      if (done) begin
         done_cnt++;
         if (rec) begin rec = 0; fin = 1; end
      end
      if (cyc > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic bit ref_bit(input logic [159:0] fr, input int i);
      return fr[8*(i/8) + 7 - (i%8)];
   endfunction

   // exp_lead < 0: turnaround already elapsed, lead must be at most one tick.
   task automatic run_frame(input bit use_edge, input logic [8:0] turn, input bit one,
                            input logic [159:0] fr, input int cnt, input bit poke,
                            input int exp_lead, input string cnt_tag);
      int za [0:255];
      int oa [0:255];
      int np, p, lead, eff, bad_gap, bad_len, bad_ord;
      @(posedge clk); #2;
      frame_data = fr; frame_len = 8'(cnt); turn_units = turn; tag_bit_one = one;
      start = 1'b1; tag_edge = use_edge; done_cnt = 0; fin = 0; tlen = 0;
      @(posedge clk); #2;
      start = 1'b0; tag_edge = 1'b0; rec = 1;
      if (poke) begin
         repeat (200) @(posedge clk);
         #2;
         chk(ready == 1'b0, "R7 ready low while busy", ready, 0);
         frame_data = ~fr; frame_len = 8'd5; turn_units = 9'd0; start = 1'b1;
         @(posedge clk); #2;
         start = 1'b0;
      end
      while (!fin) @(posedge clk);
      repeat (8) @(posedge clk);
      #2;
      chk(ready == 1'b1 && field_on == 1'b1, "R5 idle after frame", {ready, field_on}, 3);
      chk(done_cnt == 1, poke ? "R7 single done" : "R5 single done", done_cnt, 1);

      p = 0; lead = 0; np = 0;
      while (p < tlen && trc[p]) begin lead++; p++; end
      while (p < tlen && np < 256) begin
         za[np] = 0; oa[np] = 0;
         while (p < tlen && !trc[p]) begin za[np]++; p++; end
         while (p < tlen && trc[p])  begin oa[np]++; p++; end
         np++;
      end
      if (exp_lead < 0) chk(lead <= 1, "R9 immediate start", lead, 1);
      else              chk(lead == exp_lead, "R6 turnaround", lead, exp_lead);

      eff = (cnt > 160) ? 160 : cnt;
      chk(np == eff + 1, cnt_tag, np - 1, eff);
      bad_gap = 0; bad_len = 0; bad_ord = 0;
      for (int i = 0; i < np; i++) if (za[i] != 6) bad_gap++;
      chk(bad_gap == 0, "R2 gap length", bad_gap, 0);
      if (np == eff + 1) begin
         for (int i = 0; i < eff; i++) begin
            if (oa[i] != 16 && oa[i] != 22) bad_len++;
            else if ((oa[i] == 22) != ref_bit(fr, i)) bad_ord++;
         end
         chk(bad_len == 0, "R3 bit duration", bad_len, 0);
         chk(bad_ord == 0, "R4 bit order", bad_ord, 0);
         chk(za[np-1] == 6 && oa[np-1] == 0, "R5 closing gap", za[np-1], 6);
      end
   endtask

   initial begin
      logic [159:0] fr;
      void'($urandom(32'd20240611));
      repeat (5) @(posedge clk);
      #2;
      chk(field_on == 1'b1, "R1 field on in reset", field_on, 1);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk(ready == 1'b1, "R1 ready after reset", ready, 1);
      chk(field_on == 1'b1, "R1 field on idle", field_on, 1);
      chk(done == 1'b0, "R1 done low", done, 0);

      // directed: one byte, no tag edge
      run_frame(0, 9'd0, 0, {152'd0, 8'hA5}, 8, 0, -1, "R4 bit count");
      // partial byte, turnaround 90
      run_frame(1, 9'd90, 0, {144'd0, 16'h3C96}, 13, 0, 90, "R4 partial bytes");
      // last tag bit one adds 16
      run_frame(1, 9'd90, 1, {136'd0, 24'h5A0FF1}, 20, 0, 106, "R4 bit count");
      // start while busy is ignored
      run_frame(1, 9'd90, 0, {128'd0, 32'hDEADBEEF}, 32, 1, 90, "R7 frame unchanged");
      // zero-length frame
      run_frame(0, 9'd0, 0, '0, 0, 0, -1, "R8 zero bits");
      // over-long request is clamped
      fr = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      run_frame(0, 9'd0, 0, fr, 200, 0, -1, "R10 clamp to 160");

      for (int k = 0; k < 6; k++) begin
         bit ue, one;
         int turn, cnt;
         ue  = 1'($urandom_range(0, 1));
         one = 1'($urandom_range(0, 1));
         case ($urandom_range(0, 2))
            0: turn = 90;
            1: turn = 200;
            default: turn = 300;
         endcase
         cnt = $urandom_range(1, 60);
         fr  = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
         if (ue) run_frame(1, 9'(turn), one, fr, cnt, 0, turn + (one ? 16 : 0), "R4 random count");
         else    run_frame(0, 9'd0, 0, fr, cnt, 0, -1, "R4 random count");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule